// File: doc/BRIEF.md
# Instruction Length Decoder for a 32-bit x86 Subset

This block walks a stream of instruction bytes, one byte per accepted cycle, and finds where each instruction ends. It handles an optional operand-size override, an optional escape byte into the two-byte opcode space, and the addressing byte with its optional scaled-index byte. It then sizes the displacement and the trailing immediate or branch offset. When the last byte of an instruction is accepted, it reports the instruction's length and the offset of its first opcode byte. It also reports flags that tell which optional fields were present.

Bytes arrive through a valid/ready pair. The ready output stays high once reset is released, so the block never applies back-pressure. A front end can feed bytes continuously, and instruction boundaries come out on a single-cycle pulse. An opcode outside the supported set raises an error flag on that pulse. The next byte then starts a fresh instruction, so the stream resynchronises by itself.

Top module: `insn_len_decoder`

## Requirements
- R1: While `rst` is high, `in_ready` and `out_done` are low. `in_ready` is high from the first clock edge after `rst` falls.
- R2: Each of the bytes 0x40 to 0x4F, 0xC3, 0xED, 0xEF and 0xF4 is a complete instruction with length 1, opcode offset 0 and all field flags low.
- R3: `out_done` is high for exactly one cycle, in the cycle after the clock edge that accepted an instruction's last byte. The byte accepted on the next edge is decoded as the first byte of a new instruction, with no idle cycle needed.
- R4: Opcodes 0xB8 to 0xBF carry a 4-byte immediate (length 5). When preceded by 0x66, they carry a 2-byte immediate (length 4) and report opcode offset 1.
- R5: Opcodes 0x01, 0x03, 0x29, 0x89 and 0x8B take an addressing byte (mod = bits 7:6, r/m = bits 2:0) and no immediate. With mod = 3, or with mod = 0 and r/m other than 4 or 5, the length is 2, `out_modrm` is high and `out_disp` is low.
- R6: For an addressing byte with r/m ≠ 4, mod = 1 adds one displacement byte and mod = 2 adds four.
- R7: When mod ≠ 3 and r/m = 4, a scaled-index byte follows the addressing byte. It adds one to the length and sets `out_sib`.
- R8: mod = 0 with r/m = 5 adds a 4-byte displacement. mod = 0 with a scaled-index byte whose base field (bits 2:0) is 5 also adds a 4-byte displacement.
- R9: 0x81 takes an addressing byte plus a 4-byte immediate (2 bytes after 0x66). 0x83 takes an addressing byte plus a 1-byte immediate. Both set `out_imm`.
- R10: 0xE9 carries a 4-byte offset, while 0xEB and 0x70 to 0x7F carry a 1-byte offset. 0x0F followed by 0x80 to 0x8F carries a 4-byte offset, sets `out_two_byte` and reports the offset of the 0x0F byte. These offset sizes do not change with a 0x66 prefix. Offsets set `out_imm`.
- R11: An unsupported opcode ends the instruction with `out_err` and `out_done` both high. `out_len` counts the bytes consumed so far, which is 1 for a lone bad opcode. `out_modrm`, `out_sib`, `out_disp` and `out_imm` are low. A second 0x66 and a 0x0F followed by a byte outside 0x80 to 0x8F both count as unsupported. Decoding restarts on the next byte.
- R12: Cycles with `in_valid` low change no decode state, and no `out_done` pulse comes from them.
- R13: The longest supported form is 11 bytes: 0x81, an addressing byte with a scaled-index byte, a 4-byte displacement and a 4-byte immediate. It is reported with all four field flags high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction byte is present |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| out_done | output | 1 | One-cycle pulse: an instruction ended |
| out_err | output | 1 | The instruction that ended was unsupported |
| out_len | output | LEN_W | Total length in bytes |
| out_opc_ofs | output | LEN_W | Byte offset of the first opcode byte |
| out_two_byte | output | 1 | The escape byte 0x0F was seen |
| out_modrm | output | 1 | Addressing byte present |
| out_sib | output | 1 | Scaled-index byte present |
| out_disp | output | 1 | Displacement present |
| out_imm | output | 1 | Immediate or branch offset present |

## Verification
The two events that share a cycle are the end-of-instruction report for one instruction and the acceptance of the first byte of the next. A third case is an error report in the same cycle as the restart on the following byte. The bench provokes both by streaming instructions back to back with `in_valid` held high. This includes single-byte opcodes on consecutive cycles and a bad opcode immediately followed by a good one. Every report is captured in order, and each length and flag set must match the expected value for its own instruction, with no merged or missing pulses.

// File: rtl/ild_pkg.sv
package ild_pkg;
  localparam int BYTE_W = 8;
  localparam int FLD_W  = 3;   // width of a field byte count (0..4)
  localparam logic [BYTE_W-1:0] OPSIZE_PFX = 8'h66;
  localparam logic [BYTE_W-1:0] ESC_BYTE   = 8'h0F;

  typedef enum logic [2:0] {
    ST_OPC,
    ST_ESC,
    ST_MODRM,
    ST_SIB,
    ST_TAIL
  } ild_state_e;

  typedef struct packed {
    logic             ok;
    logic             modrm;
    logic [FLD_W-1:0] imm_bytes;
  } op_info_t;
endpackage

// File: rtl/ild_opclass.sv
module ild_opclass
  import ild_pkg::*;
(
  input  logic [BYTE_W-1:0] opc,
  input  logic              esc,
  input  logic              wide16,
  output op_info_t          info
);
  logic [FLD_W-1:0] iv_bytes;

  always_comb begin
    iv_bytes = wide16 ? FLD_W'(2) : FLD_W'(4);
    info = '0;
    if (esc) begin
      if (opc inside {[8'h80:8'h8F]}) begin
        info.ok = 1'b1;
        info.imm_bytes = FLD_W'(4);
      end
    end else if (opc inside {[8'h40:8'h4F], 8'hC3, 8'hED, 8'hEF, 8'hF4}) begin
      info.ok = 1'b1;
    end else if (opc inside {[8'hB8:8'hBF]}) begin
      info.ok = 1'b1;
      info.imm_bytes = iv_bytes;
    end else if (opc == 8'h81) begin
      info.ok = 1'b1;
      info.modrm = 1'b1;
      info.imm_bytes = iv_bytes;
    end else if (opc == 8'h83) begin
      info.ok = 1'b1;
      info.modrm = 1'b1;
      info.imm_bytes = FLD_W'(1);
    end else if (opc inside {8'h01, 8'h03, 8'h29, 8'h89, 8'h8B}) begin
      info.ok = 1'b1;
      info.modrm = 1'b1;
    end else if (opc == 8'hE9) begin
      info.ok = 1'b1;
      info.imm_bytes = FLD_W'(4);
    end else if (opc inside {8'hEB, [8'h70:8'h7F]}) begin
      info.ok = 1'b1;
      info.imm_bytes = FLD_W'(1);
    end
  end
endmodule

// File: rtl/ild_addr_calc.sv
module ild_addr_calc
  import ild_pkg::*;
(
  input  logic [1:0]       mod_now,
  input  logic [2:0]       rm_now,
  input  logic [1:0]       mod_held,
  input  logic [2:0]       sib_base,
  output logic             need_sib,
  output logic [FLD_W-1:0] disp_modrm,
  output logic [FLD_W-1:0] disp_sib
);
  always_comb begin
    need_sib = (mod_now != 2'b11) && (rm_now == 3'b100);
    unique case (mod_now)
      2'b00:   disp_modrm = (rm_now == 3'b101) ? FLD_W'(4) : FLD_W'(0);
      2'b01:   disp_modrm = FLD_W'(1);
      2'b10:   disp_modrm = FLD_W'(4);
      default: disp_modrm = FLD_W'(0);
    endcase
    unique case (mod_held)
      2'b00:   disp_sib = (sib_base == 3'b101) ? FLD_W'(4) : FLD_W'(0);
      2'b01:   disp_sib = FLD_W'(1);
      2'b10:   disp_sib = FLD_W'(4);
      default: disp_sib = FLD_W'(0);
    endcase
  end
endmodule

// File: rtl/ild_ctrl.sv
module ild_ctrl
  import ild_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [BYTE_W-1:0] cur_byte,
  input  op_info_t          op,
  input  logic              need_sib,
  input  logic [FLD_W-1:0]  disp_modrm,
  input  logic [FLD_W-1:0]  disp_sib,
  output logic              esc_phase,
  output logic              wide16,
  output logic [1:0]        mod_held,
  output logic              ready,
  output logic              done,
  output logic              err,
  output logic [LEN_W-1:0]  len,
  output logic [LEN_W-1:0]  opc_ofs,
  output logic              two_byte,
  output logic              f_modrm,
  output logic              f_sib,
  output logic              f_disp,
  output logic              f_imm
);
  localparam int REM_W = FLD_W + 1;

  ild_state_e       st_q, st_d;
  logic [LEN_W-1:0] cnt_q, ofs_q, ofs_d;
  logic             pfx_q, pfx_d, esc_q, esc_d;
  logic             mrm_q, mrm_d, sib_q, sib_d, dsp_q, dsp_d, imm_q, imm_d;
  logic [FLD_W-1:0] immb_q, immb_d;
  logic [REM_W-1:0] rem_q, rem_d;
  logic [1:0]       mod_q, mod_d;
  logic             fin, bad, take_op;

  assign esc_phase = (st_q == ST_ESC);
  assign wide16    = pfx_q;
  assign mod_held  = mod_q;

  always_comb begin
    st_d = st_q;   ofs_d = ofs_q;  pfx_d = pfx_q;  esc_d = esc_q;
    mrm_d = mrm_q; sib_d = sib_q;  dsp_d = dsp_q;  imm_d = imm_q;
    immb_d = immb_q; rem_d = rem_q; mod_d = mod_q;
    fin = 1'b0; bad = 1'b0; take_op = 1'b0;
    unique case (st_q)
      ST_OPC: begin
        if (cur_byte == OPSIZE_PFX && !pfx_q) begin
          pfx_d = 1'b1;
        end else if (cur_byte == ESC_BYTE) begin
          esc_d = 1'b1;
          ofs_d = cnt_q;
          st_d  = ST_ESC;
        end else begin
          ofs_d   = cnt_q;
          take_op = 1'b1;
        end
      end
      ST_ESC: take_op = 1'b1;
      ST_MODRM: begin
        mod_d = cur_byte[7:6];
        dsp_d = (disp_modrm != '0);
        if (need_sib) begin
          sib_d = 1'b1;
          st_d  = ST_SIB;
        end else begin
          rem_d = REM_W'(disp_modrm) + REM_W'(immb_q);
          if (rem_d == '0) fin = 1'b1;
          else st_d = ST_TAIL;
        end
      end
      ST_SIB: begin
        dsp_d = (disp_sib != '0);
        rem_d = REM_W'(disp_sib) + REM_W'(immb_q);
        if (rem_d == '0) fin = 1'b1;
        else st_d = ST_TAIL;
      end
      default: begin
        rem_d = rem_q - 1'b1;
        if (rem_q == REM_W'(1)) fin = 1'b1;
      end
    endcase

    if (take_op) begin
      if (!op.ok) begin
        bad = 1'b1;
        fin = 1'b1;
      end else begin
        immb_d = op.imm_bytes;
        imm_d  = (op.imm_bytes != '0);
        if (op.modrm) begin
          mrm_d = 1'b1;
          st_d  = ST_MODRM;
        end else if (op.imm_bytes != '0) begin
          rem_d = REM_W'(op.imm_bytes);
          st_d  = ST_TAIL;
        end else begin
          fin = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_OPC; cnt_q <= '0; ofs_q <= '0; pfx_q <= 1'b0; esc_q <= 1'b0;
      mrm_q <= 1'b0; sib_q <= 1'b0; dsp_q <= 1'b0; imm_q <= 1'b0;
      immb_q <= '0; rem_q <= '0; mod_q <= '0;
      ready <= 1'b0; done <= 1'b0; err <= 1'b0;
      len <= '0; opc_ofs <= '0; two_byte <= 1'b0;
      f_modrm <= 1'b0; f_sib <= 1'b0; f_disp <= 1'b0; f_imm <= 1'b0;
    end else begin
      ready <= 1'b1;
      done  <= fire && fin;
      err   <= fire && bad;
      if (fire) begin
        if (fin) begin
          len      <= cnt_q + 1'b1;
          opc_ofs  <= ofs_d;
          two_byte <= esc_d;
          f_modrm  <= mrm_d & ~bad;
          f_sib    <= sib_d & ~bad;
          f_disp   <= dsp_d & ~bad;
          f_imm    <= imm_d & ~bad;
          st_q <= ST_OPC; cnt_q <= '0; ofs_q <= '0; pfx_q <= 1'b0; esc_q <= 1'b0;
          mrm_q <= 1'b0; sib_q <= 1'b0; dsp_q <= 1'b0; imm_q <= 1'b0;
          immb_q <= '0; rem_q <= '0; mod_q <= '0;
        end else begin
          st_q <= st_d; cnt_q <= cnt_q + 1'b1; ofs_q <= ofs_d;
          pfx_q <= pfx_d; esc_q <= esc_d;
          mrm_q <= mrm_d; sib_q <= sib_d; dsp_q <= dsp_d; imm_q <= imm_d;
          immb_q <= immb_d; rem_q <= rem_d; mod_q <= mod_d;
        end
      end
    end
  end
endmodule

// File: rtl/insn_len_decoder.sv
module insn_len_decoder
  import ild_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic              in_ready,
  output logic              out_done,
  output logic              out_err,
  output logic [LEN_W-1:0]  out_len,
  output logic [LEN_W-1:0]  out_opc_ofs,
  output logic              out_two_byte,
  output logic              out_modrm,
  output logic              out_sib,
  output logic              out_disp,
  output logic              out_imm
);
  op_info_t         op;
  logic             esc_phase, wide16, need_sib, fire;
  logic [1:0]       mod_held;
  logic [FLD_W-1:0] disp_modrm, disp_sib;

  assign fire = in_valid && in_ready;

  ild_opclass u_cls (
    .opc    (in_byte),
    .esc    (esc_phase),
    .wide16 (wide16),
    .info   (op)
  );

  ild_addr_calc u_addr (
    .mod_now    (in_byte[7:6]),
    .rm_now     (in_byte[2:0]),
    .mod_held   (mod_held),
    .sib_base   (in_byte[2:0]),
    .need_sib   (need_sib),
    .disp_modrm (disp_modrm),
    .disp_sib   (disp_sib)
  );

  ild_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .fire       (fire),
    .cur_byte   (in_byte),
    .op         (op),
    .need_sib   (need_sib),
    .disp_modrm (disp_modrm),
    .disp_sib   (disp_sib),
    .esc_phase  (esc_phase),
    .wide16     (wide16),
    .mod_held   (mod_held),
    .ready      (in_ready),
    .done       (out_done),
    .err        (out_err),
    .len        (out_len),
    .opc_ofs    (out_opc_ofs),
    .two_byte   (out_two_byte),
    .f_modrm    (out_modrm),
    .f_sib      (out_sib),
    .f_disp     (out_disp),
    .f_imm      (out_imm)
  );
endmodule

// File: rtl/ild_chk.sv
module ild_chk #(
  parameter int LEN_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_done,
  input logic             out_err,
  input logic [LEN_W-1:0] out_len,
  input logic             out_modrm,
  input logic             out_sib,
  input logic             out_imm
);
  localparam int MAX_LEN = 11;

  // R1
  ready_up_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> in_ready);

  // R3
  done_after_byte_chk: assert property (@(posedge clk) disable iff (rst)
    out_done |-> $past(in_valid && in_ready));

  // R11
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    out_err |-> out_done);

  // R11
  err_no_fields_chk: assert property (@(posedge clk) disable iff (rst)
    out_err |-> (!out_modrm && !out_sib && !out_imm));

  // R7
  sib_needs_modrm_chk: assert property (@(posedge clk) disable iff (rst)
    (out_done && out_sib) |-> (out_modrm && out_len >= LEN_W'(3)));

  // R13
  len_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_done |-> (out_len >= LEN_W'(1) && out_len <= LEN_W'(MAX_LEN)));
endmodule

bind insn_len_decoder ild_chk #(.LEN_W(LEN_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_done  (out_done),
  .out_err   (out_err),
  .out_len   (out_len),
  .out_modrm (out_modrm),
  .out_sib   (out_sib),
  .out_imm   (out_imm)
);

// File: tb/sim_insn_len_decoder.sv
module sim_insn_len_decoder;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [7:0]    in_byte = 8'h00;
  logic          in_ready, out_done, out_err, out_two_byte;
  logic          out_modrm, out_sib, out_disp, out_imm;
  logic [LW-1:0] out_len, out_opc_ofs;

  always #4 clk = ~clk;

  insn_len_decoder #(.LEN_W(LW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .out_done(out_done), .out_err(out_err),
    .out_len(out_len), .out_opc_ofs(out_opc_ofs), .out_two_byte(out_two_byte),
    .out_modrm(out_modrm), .out_sib(out_sib), .out_disp(out_disp), .out_imm(out_imm)
  );

  typedef struct packed {
    logic          err;
    logic [LW-1:0] len;
    logic [LW-1:0] ofs;
    logic          two;
    logic          modrm;
    logic          sib;
    logic          disp;
    logic          imm;
  } rec_t;

  rec_t rq[$];
  int   checks = 0;
  int   fails  = 0;
  bit   finished = 1'b0;

  always @(negedge clk)
    if (!rst && out_done)
      rq.push_back({out_err, out_len, out_opc_ofs, out_two_byte,
                    out_modrm, out_sib, out_disp, out_imm});

  function automatic rec_t mk(logic e, int l, int o, logic t, logic m,
                              logic s, logic d, logic i);
    return {e, LW'(l), LW'(o), t, m, s, d, i};
  endfunction

  task automatic check_bit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic expect_rec(string req, rec_t exp);
    rec_t a;
    checks++;
    if (rq.size() == 0) begin
      fails++;
      $display("FAIL %s: actual no report expected %h", req, exp);
    end else begin
      a = rq.pop_front();
      if (a !== exp) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", req, a, exp);
      end
    end
  endtask

  task automatic expect_count(string req, int n);
    checks++;
    if (rq.size() != n) begin
      fails++;
      $display("FAIL %s: actual %0d reports expected %0d", req, rq.size(), n);
    end
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
  endtask

  task automatic send_n(logic [8*12-1:0] v, int n);
    for (int i = 0; i < n; i++) send(v[8*(n-1-i) +: 8]);
  endtask

  task automatic flush();
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check_bit("R1 ready in reset", in_ready, 1'b0);
    check_bit("R1 done in reset", out_done, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check_bit("R1 ready after reset", in_ready, 1'b1);
  endtask

  task automatic t_single();
    rq.delete();
    send_n({8'h40, 8'h4F, 8'hC3, 8'hED, 8'hEF, 8'hF4}, 6);
    flush();
    expect_count("R2 R3 back-to-back singles", 6);
    for (int i = 0; i < 6; i++) expect_rec("R2 single byte", mk(0,1,0,0,0,0,0,0));
  endtask

  task automatic t_timing();
    rq.delete();
    send(8'hC3);
    @(negedge clk);
    in_valid = 1'b0;
    check_bit("R3 done one cycle after byte", out_done, 1'b1);
    @(negedge clk);
    check_bit("R3 done lasts one cycle", out_done, 1'b0);
    flush();
    rq.delete();
  endtask

  task automatic t_movimm();
    rq.delete();
    send_n({8'hB8, 8'h11, 8'h22, 8'h33, 8'h44}, 5);
    send_n({8'h66, 8'hBB, 8'h01, 8'h02}, 4);
    flush();
    expect_rec("R4 mov imm32", mk(0,5,0,0,0,0,0,1));
    expect_rec("R4 mov imm16 prefixed", mk(0,4,1,0,0,0,0,1));
  endtask

  task automatic t_modrm();
    rq.delete();
    send_n({8'h89, 8'hC1}, 2);
    send_n({8'h29, 8'h00}, 2);
    send_n({8'h01, 8'h45, 8'h08}, 3);
    send_n({8'h03, 8'hB8, 8'h01, 8'h02, 8'h03, 8'h04}, 6);
    send_n({8'h8B, 8'h05, 8'hAA, 8'hBB, 8'hCC, 8'hDD}, 6);
    flush();
    expect_rec("R5 mod3 register", mk(0,2,0,0,1,0,0,0));
    expect_rec("R5 mod0 no disp", mk(0,2,0,0,1,0,0,0));
    expect_rec("R6 mod1 disp8", mk(0,3,0,0,1,0,1,0));
    expect_rec("R6 mod2 disp32", mk(0,6,0,0,1,0,1,0));
    expect_rec("R8 mod0 rm5 absolute", mk(0,6,0,0,1,0,1,0));
  endtask

  task automatic t_sib();
    rq.delete();
    send_n({8'h8B, 8'h04, 8'h24}, 3);
    send_n({8'h89, 8'h44, 8'h24, 8'h08}, 4);
    send_n({8'h8B, 8'h04, 8'h25, 8'h10, 8'h20, 8'h30, 8'h40}, 7);
    flush();
    expect_rec("R7 sib mod0", mk(0,3,0,0,1,1,0,0));
    expect_rec("R7 sib mod1 disp8", mk(0,4,0,0,1,1,1,0));
    expect_rec("R8 sib base5 disp32", mk(0,7,0,0,1,1,1,0));
  endtask

  task automatic t_group_imm();
    rq.delete();
    send_n({8'h81, 8'hC1, 8'h01, 8'h02, 8'h03, 8'h04}, 6);
    send_n({8'h66, 8'h81, 8'hC1, 8'h01, 8'h02}, 5);
    send_n({8'h83, 8'hE9, 8'h20}, 3);
    send_n({8'h81, 8'h84, 8'h24, 8'h1, 8'h2, 8'h3, 8'h4, 8'h5, 8'h6, 8'h7, 8'h8}, 11);
    flush();
    expect_rec("R9 0x81 imm32", mk(0,6,0,0,1,0,0,1));
    expect_rec("R9 0x81 imm16 prefixed", mk(0,5,1,0,1,0,0,1));
    expect_rec("R9 0x83 imm8", mk(0,3,0,0,1,0,0,1));
    expect_rec("R13 longest form", mk(0,11,0,0,1,1,1,1));
  endtask

  task automatic t_branch();
    rq.delete();
    send_n({8'hE9, 8'h01, 8'h02, 8'h03, 8'h04}, 5);
    send_n({8'hEB, 8'h05}, 2);
    send_n({8'h70, 8'hFE}, 2);
    send_n({8'h7F, 8'h00}, 2);
    send_n({8'h0F, 8'h84, 8'h01, 8'h02, 8'h03, 8'h04}, 6);
    send_n({8'h66, 8'h0F, 8'h85, 8'h01, 8'h02, 8'h03, 8'h04}, 7);
    send_n({8'h66, 8'hE9, 8'h01, 8'h02, 8'h03, 8'h04}, 6);
    flush();
    expect_rec("R10 near jump", mk(0,5,0,0,0,0,0,1));
    expect_rec("R10 short jump", mk(0,2,0,0,0,0,0,1));
    expect_rec("R10 jcc short low", mk(0,2,0,0,0,0,0,1));
    expect_rec("R10 jcc short high", mk(0,2,0,0,0,0,0,1));
    expect_rec("R10 escaped jcc", mk(0,6,0,1,0,0,0,1));
    expect_rec("R10 prefixed escaped jcc", mk(0,7,1,1,0,0,0,1));
    expect_rec("R10 prefixed near jump", mk(0,6,1,0,0,0,0,1));
  endtask

  task automatic t_error();
    rq.delete();
    send(8'h90);
    send(8'h40);
    send_n({8'h0F, 8'h05}, 2);
    send_n({8'h66, 8'h66}, 2);
    send(8'hC3);
    flush();
    expect_rec("R11 lone bad opcode", mk(1,1,0,0,0,0,0,0));
    expect_rec("R11 restart after error", mk(0,1,0,0,0,0,0,0));
    expect_rec("R11 bad escaped opcode", mk(1,2,0,1,0,0,0,0));
    expect_rec("R11 double prefix", mk(1,2,1,0,0,0,0,0));
    expect_rec("R11 good after double prefix", mk(0,1,0,0,0,0,0,0));
  endtask

  task automatic t_stall();
    rq.delete();
    send(8'hB8);
    @(negedge clk) in_valid = 1'b0;
    repeat (3) @(negedge clk);
    send_n({8'h11, 8'h22}, 2);
    @(negedge clk) in_valid = 1'b0;
    repeat (2) @(negedge clk);
    send(8'h33);
    @(negedge clk) in_valid = 1'b0;
    repeat (2) @(negedge clk);
    expect_count("R12 no report during gaps", 0);
    send(8'h44);
    flush();
    expect_rec("R12 gapped mov imm32", mk(0,5,0,0,0,0,0,1));
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  initial begin
    t_reset();
    t_single();
    t_timing();
    t_movimm();
    t_modrm();
    t_sib();
    t_group_imm();
    t_branch();
    t_error();
    t_stall();
    summary();
  end
endmodule